// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block holds the single 32-bit control and status word of a floating-point unit. Software reads and writes it as one word. The arithmetic datapaths feed it exception events, comparison outcomes and saturation events. The block decodes its control fields into steady control outputs for the single/double-precision path and the half-precision path.

The stored state is kept in several pieces. The first piece is the main control storage, which holds the condition flags, the mode bits and the rounding field. The other pieces are the vector length and stride fields, the sticky cumulative exception flags, and four saturation sources. A read merges these pieces into one word, and the bits that have no storage read as zero. When a software write and datapath events arrive in the same cycle, the write wins and the events of that cycle are dropped.

Top module: `fp_ctl_status_reg`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0, both rounding outputs are 0 (nearest-even), and the flush, default-NaN, length and stride outputs are all 0.
- R2: A write keeps only the readable bits 31:28, 26:16, 7 and 4:0. Bit 27 is the saturation flag. Bits 15:8, 6 and 5 always read 0, whatever was written to them.
- R3: Rounding field bits 23:22 drive both `rm_main` and `rm_half`: 0 nearest-even, 1 toward +inf, 2 toward -inf, 3 toward zero.
- R4: The control outputs follow the stored word: `ftz_main` is bit 24, `ftz_half` is bit 19, `dnan_en` is bit 25, `vec_len` is bits 18:16 and `vec_stride` is bits 21:20. Bit 26 is stored and read back.
- R5: The event vector bits are 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 output-denormal and 6 input-denormal. An event on the main path sets a sticky flag: invalid at bit 0, divide-by-zero at bit 1, overflow at bit 2, underflow at bit 3, inexact at bit 4 and input-denormal at bit 7.
- R6: An output-denormal event sets the underflow flag at bit 3, the same flag that an underflow event sets.
- R7: Events from the half-precision path set the same flags as main-path events, except that a half-path input-denormal event is ignored.
- R8: A compare strobe writes bits 31:28 from the relation code. The codes map as follows: 0 (equal) gives 0110, 1 (less) gives 1000, 2 (greater) gives 0010 and 3 (unordered) gives 0011.
- R9: Bit 27 reads 1 when any of the four saturation sources is set. A `sat_set` bit sets its own source. A write loads source 0 from `wr_data[27]` and clears the other three sources.
- R10: A write in the same cycle as flag raises, a compare or saturation sets takes priority: the word holds exactly what was written.
- R11: With `HALF_EN` set to 0, bit 19 is forced to 0 on every write.
- R12: Sticky flags and saturation stay set on cycles without a write. Only a write clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Whole-word software write strobe |
| wr_data | input | 32 | Word to be written |
| rd_data | output | 32 | Merged read value |
| raise_main | input | 7 | Exception events from the single/double path |
| raise_half | input | 7 | Exception events from the half-precision path |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_rel | input | 2 | Compare relation code |
| sat_set | input | 4 | Per-source saturation events |
| rm_main | output | 2 | Rounding mode to the single/double path |
| rm_half | output | 2 | Rounding mode to the half-precision path |
| ftz_main | output | 1 | Flush-to-zero for the single/double path |
| ftz_half | output | 1 | Flush-to-zero for the half-precision path |
| dnan_en | output | 1 | Default-NaN mode |
| vec_len | output | 3 | Vector length field |
| vec_stride | output | 2 | Vector stride field |

## Verification
The hardest situation to reach is a cycle in which a software write coincides with flag raises, a compare and saturation sets, because the datapath sources must be driven at the exact cycle of the write. The stimulus drives that collision on purpose in directed steps. It also drives many random steps in which all input groups toggle independently, and it checks the merged read against a behavioural model after every clock. A second instance built without half-precision support receives the same stimulus, so the forced-zero bit 19 is checked on every write.

// File: rtl/fpcsr_pkg.sv
// Shared encodings and field positions for the floating-point control word.
// Assumes a 32-bit word; positions here are decoded by the datapaths.
package fpcsr_pkg;
    localparam int WORD_W      = 32;
    localparam int EV_W        = 7;
    localparam int FLAG_W      = 6;
    localparam int N_SAT       = 4;
    localparam int LEN_LO      = 16;
    localparam int LEN_W       = 3;
    localparam int FTZ_HALF_B  = 19;
    localparam int STRIDE_LO   = 20;
    localparam int STRIDE_W    = 2;
    localparam int RM_LO       = 22;
    localparam int FTZ_B       = 24;
    localparam int DNAN_B      = 25;
    localparam int SAT_B       = 27;
    localparam int CC_LO       = 28;
    localparam logic [WORD_W-1:0] CTRL_KEEP = 32'hF7C8_0000;

    // event vector positions
    localparam int EV_INVALID  = 0;
    localparam int EV_DIVZERO  = 1;
    localparam int EV_OVERFLOW = 2;
    localparam int EV_UNDERFL  = 3;
    localparam int EV_INEXACT  = 4;
    localparam int EV_OUTDEN   = 5;
    localparam int EV_INDEN    = 6;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_POS_INF = 2'd1,
        RM_NEG_INF = 2'd2,
        RM_ZERO    = 2'd3
    } round_mode_e;

    // Condition nibble for a compare relation code.
    function automatic logic [3:0] cc_encode(input logic [1:0] rel);
        case (rel)
            2'd0:    cc_encode = 4'b0110;
            2'd1:    cc_encode = 4'b1000;
            2'd2:    cc_encode = 4'b0010;
            default: cc_encode = 4'b0011;
        endcase
    endfunction
endpackage

// File: rtl/fpcsr_ctrl_store.sv
// Main control storage plus the vector length and stride fields.
// Assumes: a write wins over a compare strobe in the same cycle.
module fpcsr_ctrl_store
    import fpcsr_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                cmp_valid,
    input  logic [1:0]          cmp_rel,
    output logic [WORD_W-1:0]   ctrl_word,
    output logic [LEN_W-1:0]    len_q,
    output logic [STRIDE_W-1:0] stride_q
);
    localparam logic [WORD_W-1:0] HALF_BIT  = WORD_W'(1) << FTZ_HALF_B;
    localparam logic [WORD_W-1:0] KEEP_MASK = HALF_EN ? CTRL_KEEP : (CTRL_KEEP & ~HALF_BIT);

    logic [WORD_W-1:0] ctrl_q;

    // Load on write, otherwise fold in compare results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            len_q    <= '0;
            stride_q <= '0;
        end else if (wr_en) begin
            ctrl_q   <= wr_data & KEEP_MASK;
            len_q    <= wr_data[LEN_LO +: LEN_W];
            stride_q <= wr_data[STRIDE_LO +: STRIDE_W];
        end else if (cmp_valid) begin
            ctrl_q[CC_LO +: 4] <= cc_encode(cmp_rel);
        end
    end

    assign ctrl_word = ctrl_q;

    a_r8_less_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cmp_valid && cmp_rel == 2'd1) |=> (ctrl_q[CC_LO +: 4] == 4'b1000));
    a_r2_mode_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q[26:22] == $past(wr_data[26:22])));

    generate
        if (!HALF_EN) begin : g_no_half
            a_r11_half_ftz_zero: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> !ctrl_q[FTZ_HALF_B]);
        end
    endgenerate
endmodule

// File: rtl/fpcsr_flag_accum.sv
// Sticky cumulative exception flags fed by two datapaths.
// Assumes: half-path input-denormal is ignored; a write wins over raises.
module fpcsr_flag_accum
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_flags,
    input  logic [EV_W-1:0]   raise_main,
    input  logic [EV_W-1:0]   raise_half,
    output logic [7:0]        flag_word
);
    logic [FLAG_W-1:0] flags_q;
    logic [EV_W-1:0]   half_masked;
    logic [EV_W-1:0]   ev_all;
    logic [FLAG_W-1:0] ev_flags;

    // Merge both event sources into flag order.
    always_comb begin
        half_masked             = raise_half;
        half_masked[EV_INDEN]   = 1'b0;
        ev_all                  = raise_main | half_masked;
        ev_flags[0] = ev_all[EV_INVALID];
        ev_flags[1] = ev_all[EV_DIVZERO];
        ev_flags[2] = ev_all[EV_OVERFLOW];
        ev_flags[3] = ev_all[EV_UNDERFL] | ev_all[EV_OUTDEN];
        ev_flags[4] = ev_all[EV_INEXACT];
        ev_flags[5] = ev_all[EV_INDEN];
    end

    // Load on write, otherwise accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (wr_en) flags_q <= {wr_flags[7], wr_flags[4:0]};
        else            flags_q <= flags_q | ev_flags;
    end

    assign flag_word = {flags_q[5], 2'b00, flags_q[4:0]};

    a_r12_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    a_r6_outden_to_uf: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && raise_main[EV_OUTDEN]) |=> flags_q[3]);
    a_r5_invalid_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && raise_main[EV_INVALID]) |=> flags_q[0]);
endmodule

// File: rtl/fpcsr_sat_track.sv
// Saturation sources; the flag reads as the OR of all sources.
// Assumes: a write loads source 0 and clears the rest.
module fpcsr_sat_track
    import fpcsr_pkg::*;
#(
    parameter int N_SRC = N_SAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic [N_SRC-1:0] sat_set,
    output logic             sat_any
);
    logic [N_SRC-1:0] src_q;

    // Per-source sticky storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     src_q <= '0;
        else if (wr_en) src_q <= {{(N_SRC-1){1'b0}}, wr_bit};
        else            src_q <= src_q | sat_set;
    end

    assign sat_any = |src_q;

    a_r9_write_loads_src0: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (src_q[N_SRC-1:1] == '0 && src_q[0] == $past(wr_bit)));
    a_r10_write_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit) |=> !sat_any);
endmodule

// File: rtl/fp_ctl_status_reg.sv
// Floating-point control/status word: merges separately held fields on
// read and decodes control fields for the datapaths.
// Assumes: all state is registered; rd_data is combinational from state.
module fp_ctl_status_reg
    import fpcsr_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [6:0]  raise_main,
    input  logic [6:0]  raise_half,
    input  logic        cmp_valid,
    input  logic [1:0]  cmp_rel,
    input  logic [3:0]  sat_set,
    output logic [1:0]  rm_main,
    output logic [1:0]  rm_half,
    output logic        ftz_main,
    output logic        ftz_half,
    output logic        dnan_en,
    output logic [2:0]  vec_len,
    output logic [1:0]  vec_stride
);
    logic [WORD_W-1:0]   ctrl_word;
    logic [LEN_W-1:0]    len_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [7:0]          flag_word;
    logic                sat_any;
    round_mode_e         rm_dec;

    fpcsr_ctrl_store #(.HALF_EN(HALF_EN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmp_valid(cmp_valid), .cmp_rel(cmp_rel),
        .ctrl_word(ctrl_word), .len_q(len_q), .stride_q(stride_q)
    );

    fpcsr_flag_accum u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_flags(wr_data[7:0]),
        .raise_main(raise_main), .raise_half(raise_half), .flag_word(flag_word)
    );

    fpcsr_sat_track #(.N_SRC(N_SAT)) u_sat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_data[SAT_B]),
        .sat_set(sat_set), .sat_any(sat_any)
    );

    // Assemble the read word from its separate pieces.
    always_comb begin
        rd_data                          = ctrl_word;
        rd_data[LEN_LO +: LEN_W]         = len_q;
        rd_data[STRIDE_LO +: STRIDE_W]   = stride_q;
        rd_data[SAT_B]                   = sat_any;
        rd_data[7:0]                     = flag_word;
    end

    // Decode control fields for both datapaths.
    always_comb begin
        rm_dec     = round_mode_e'(ctrl_word[RM_LO +: 2]);
        rm_main    = rm_dec;
        rm_half    = rm_dec;
        ftz_main   = ctrl_word[FTZ_B];
        ftz_half   = ctrl_word[FTZ_HALF_B];
        dnan_en    = ctrl_word[DNAN_B];
        vec_len    = len_q;
        vec_stride = stride_q;
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:8] == 8'h00 && rd_data[6:5] == 2'b00);
endmodule

// File: tb/test_fp_ctl_status_reg.sv
`timescale 1ns/1ps
module test_fp_ctl_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  raise_main = '0, raise_half = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [3:0]  sat_set = '0;
    logic [31:0] rd_data, rd_data_nh;
    logic [1:0]  rm_main, rm_half, rm_main_nh, rm_half_nh;
    logic        ftz_main, ftz_half, dnan_en, ftz_main_nh, ftz_half_nh, dnan_nh;
    logic [2:0]  vec_len, vec_len_nh;
    logic [1:0]  vec_stride, vec_stride_nh;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_ctrl;
    logic [2:0]  m_len;
    logic [1:0]  m_stride;
    logic [7:0]  m_flags;
    logic [3:0]  m_sat;

    always #4 clk = ~clk;

    fp_ctl_status_reg i_fp_ctl_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .raise_main(raise_main), .raise_half(raise_half), .cmp_valid(cmp_valid),
        .cmp_rel(cmp_rel), .sat_set(sat_set), .rm_main(rm_main), .rm_half(rm_half),
        .ftz_main(ftz_main), .ftz_half(ftz_half), .dnan_en(dnan_en),
        .vec_len(vec_len), .vec_stride(vec_stride)
    );

    fp_ctl_status_reg #(.HALF_EN(1'b0)) i_fp_ctl_status_reg_nohalf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data_nh),
        .raise_main(raise_main), .raise_half(raise_half), .cmp_valid(cmp_valid),
        .cmp_rel(cmp_rel), .sat_set(sat_set), .rm_main(rm_main_nh), .rm_half(rm_half_nh),
        .ftz_main(ftz_main_nh), .ftz_half(ftz_half_nh), .dnan_en(dnan_nh),
        .vec_len(vec_len_nh), .vec_stride(vec_stride_nh)
    );

    function automatic logic [7:0] ev_map(input logic [6:0] ev);
        logic [7:0] f = '0;
        if (ev[0]) f[0] = 1'b1;
        if (ev[1]) f[1] = 1'b1;
        if (ev[2]) f[2] = 1'b1;
        if (ev[3] || ev[5]) f[3] = 1'b1;
        if (ev[4]) f[4] = 1'b1;
        if (ev[6]) f[7] = 1'b1;
        return f;
    endfunction

    function automatic logic [31:0] exp_word();
        logic [31:0] w = m_ctrl;
        w[18:16] = m_len;
        w[21:20] = m_stride;
        w[27]    = (m_sat != 0);
        w[7:0]   = m_flags;
        return w;
    endfunction

    task automatic model_reset();
        m_ctrl = '0; m_len = '0; m_stride = '0; m_flags = '0; m_sat = '0;
    endtask

    task automatic model_update();
        if (wr_en) begin
            m_ctrl   = wr_data & 32'hF7C80000;
            m_len    = wr_data[18:16];
            m_stride = wr_data[21:20];
            m_flags  = wr_data & 8'h9F;
            m_sat    = {3'b000, wr_data[27]};
        end else begin
            m_flags = m_flags | ev_map(raise_main) | ev_map(raise_half & 7'h3F);
            if (cmp_valid)
                case (cmp_rel)
                    2'd0: m_ctrl[31:28] = 4'b0110;
                    2'd1: m_ctrl[31:28] = 4'b1000;
                    2'd2: m_ctrl[31:28] = 4'b0010;
                    default: m_ctrl[31:28] = 4'b0011;
                endcase
            m_sat = m_sat | sat_set;
        end
    endtask

    task automatic compare(input string tag);
        logic [43:0] act, exp;
        logic [31:0] ew, ew_nh;
        ew  = exp_word();
        act = {rd_data, rm_main, rm_half, ftz_main, ftz_half, dnan_en, vec_len, vec_stride};
        exp = {ew, m_ctrl[23:22], m_ctrl[23:22], m_ctrl[24], m_ctrl[19], m_ctrl[25], m_len, m_stride};
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
        ew_nh = ew & ~32'h0008_0000;
        compared++;
        if (rd_data_nh !== ew_nh) begin
            mismatched++;
            $display("FAIL R11 (%s): actual %h expected %h", tag, rd_data_nh, ew_nh);
        end
    endtask

    task automatic step(input string tag, input logic we, input logic [31:0] wd,
                        input logic [6:0] rm, input logic [6:0] rh, input logic cv,
                        input logic [1:0] cr, input logic [3:0] ss);
        @(negedge clk);
        wr_en = we; wr_data = wd; raise_main = rm; raise_half = rh;
        cmp_valid = cv; cmp_rel = cr; sat_set = ss;
        @(posedge clk);
        #1 model_update();
        #2 compare(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 32'h0, 7'h0, 7'h0, 1'b0, 2'd0, 4'h0);
    endtask

    task automatic wr(input string tag, input logic [31:0] wd);
        step(tag, 1'b1, wd, 7'h0, 7'h0, 1'b0, 2'd0, 4'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 compare("R1 reset");

        wr("R2 all ones", 32'hFFFF_FFFF);
        wr("R2 all zero", 32'h0);
        wr("R2 reserved only", 32'h0000_FF60);
        for (int m = 0; m < 4; m++) wr("R3 rounding", 32'(m) << 22);
        wr("R4 controls", 32'h0735_0000);
        wr("R4 controls alt", 32'h04A8_0000);

        wr("R5 clear", 32'h0);
        for (int b = 0; b < 7; b++) begin
            wr("R5 clear bit", 32'h0);
            step("R5 raise main", 1'b0, 32'h0, 7'(1 << b), 7'h0, 1'b0, 2'd0, 4'h0);
            idle("R12 flag held");
        end
        wr("R6 clear", 32'h0);
        step("R6 out-denorm", 1'b0, 32'h0, 7'h20, 7'h0, 1'b0, 2'd0, 4'h0);
        wr("R7 clear", 32'h0);
        step("R7 half in-denorm ignored", 1'b0, 32'h0, 7'h0, 7'h40, 1'b0, 2'd0, 4'h0);
        step("R7 half overflow", 1'b0, 32'h0, 7'h0, 7'h04, 1'b0, 2'd0, 4'h0);
        step("R7 half all", 1'b0, 32'h0, 7'h0, 7'h7F, 1'b0, 2'd0, 4'h0);

        for (int r = 0; r < 4; r++)
            step("R8 compare", 1'b0, 32'h0, 7'h0, 7'h0, 1'b1, 2'(r), 4'h0);

        wr("R9 clear", 32'h0);
        for (int s = 0; s < 4; s++) begin
            step("R9 sat source", 1'b0, 32'h0, 7'h0, 7'h0, 1'b0, 2'd0, 4'(1 << s));
            idle("R12 sat held");
            wr("R9 write clears", 32'h0);
        end
        wr("R9 write sets", 32'h0800_0000);
        idle("R9 sat held");

        step("R10 write vs all", 1'b1, 32'h0, 7'h7F, 7'h7F, 1'b1, 2'd1, 4'hF);
        step("R10 write vs all b", 1'b1, 32'h5040_0011, 7'h7F, 7'h3F, 1'b1, 2'd3, 4'hE);
        wr("R11 half ftz", 32'h0008_0000);

        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R10 mixed", (lfsr[3:0] == 4'h0), lfsr ^ 32'h9E37_79B9,
                 (lfsr[2:0] == 3'd1) ? lfsr[12:6] : 7'h0,
                 (lfsr[5:3] == 3'd2) ? lfsr[19:13] : 7'h0,
                 lfsr[20], lfsr[22:21], (lfsr[26:24] == 3'd0) ? lfsr[30:27] : 4'h0);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule